// File: doc/BRIEF.md
# Programmable Reload Timer with Interrupt

This peripheral provides a free-running divider and a programmable 8-bit counter behind a small byte-wide register interface. Four registers are reached through a two-bit select: the divider, the counter, the reload value (modulo) and a control register. The block advances only on cycles where the one-cycle tick enable is high. The divider steps once every fixed number of ticks. The counter steps at one of four software-selected rates through a prescale accumulator.

When the counter steps past its all-ones value, it is loaded from the modulo register rather than wrapping to zero. In the same step the block emits a one-cycle interrupt request. An external interrupt-flag register latches that pulse. Masking and vectoring happen elsewhere. Writes on the bus take effect at the clock edge. If a bus write and an internal update hit the same register in the same cycle, a fixed rule decides which one wins, so the result is deterministic.

Top module: `prt_timer`

## Requirements
- R1: After reset the divider, counter, modulo, control and prescale accumulator are zero. A control read returns 0xF8 and `irq_o` is low.
- R2: `bus_sel` picks the register: 0 = divider, 1 = counter, 2 = modulo, 3 = control. `bus_rdata` shows the selected register in the same cycle, and a write with `bus_wr` high lands at the next clock edge.
- R3: The divider increments once every 256 cycles with `tick_en` high, whether or not the counter is enabled.
- R4: Any write to the divider clears it and its hidden tick count to zero, whatever the data.
- R5: Control bit 2 enables the counter. Control bits 1:0 set the number of ticks per counter increment: 0 gives 1024, 1 gives 16, 2 gives 64, 3 gives 256.
- R6: Control bits 7:3 cannot be written and always read as 1. A read returns 0xF8 OR the stored bits 2:0.
- R7: While bit 2 is 0, both the counter and the prescale accumulator hold. Re-enabling resumes from the held count.
- R8: A counter step from 0xFF loads the modulo value. `irq_o` is high for exactly the one cycle in which that reloaded value first appears.
- R9: On each enabled tick the accumulator plus one is compared against the selected threshold. If it is at or above the threshold, the threshold is subtracted and the counter steps once. Excess ticks left over after lowering the rate therefore produce back-to-back steps.
- R10: A counter write in the same cycle as a step or reload wins, and no interrupt is raised for that cycle.
- R11: A modulo write in the same cycle as a reload supplies the reloaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle timing tick |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_sel | input | 2 | Register select (0 divider, 1 counter, 2 modulo, 3 control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_o | output | 1 | One-cycle timer interrupt request |

## Verification
The counter is exercised at all four rates with exact-threshold tick bursts and one-short bursts. This separates an off-by-one prescaler from a correct one, and a swapped rate code from the right mapping. Disable/re-enable bursts with a partly filled accumulator show whether the accumulator is kept or cleared. A rate lowered with a large accumulator separates carry-by-subtraction from a plain reset to zero. Overflow is driven alone, with a same-cycle counter write, and with a same-cycle modulo write, which tells the three reload priorities apart. The bench also counts interrupt pulses, which distinguishes a one-cycle pulse from a level.

// File: rtl/prt_pkg.sv
package prt_pkg;
   typedef enum logic [1:0] {
      SEL_DIV  = 2'd0,
      SEL_CNT  = 2'd1,
      SEL_MOD  = 2'd2,
      SEL_CTRL = 2'd3
   } prt_sel_e;

   localparam int CTRL_W   = 3;
   localparam int CTRL_EN  = 2;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/prt_divider.sv
module prt_divider #(
   parameter int DATA_W    = 8,
   parameter int DIV_TICKS = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              clr,
   output logic [DATA_W-1:0] div_q
);
   localparam int SUB_W = (DIV_TICKS > 2) ? $clog2(DIV_TICKS) : 1;
   localparam bit POW2  = (DIV_TICKS == (1 << SUB_W));

   logic [SUB_W-1:0] sub_q;
   logic [SUB_W-1:0] sub_nxt;
   logic             carry;

   generate
      if (POW2) begin : g_wrap
         assign carry   = tick && (&sub_q);
         assign sub_nxt = sub_q + 1'b1;
      end else begin : g_cmp
         assign carry   = tick && (sub_q == SUB_W'(DIV_TICKS - 1));
         assign sub_nxt = carry ? '0 : sub_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         div_q <= '0;
      end else if (clr) begin
         sub_q <= '0;
         div_q <= '0;
      end else if (tick) begin
         sub_q <= sub_nxt;
         if (carry) div_q <= div_q + 1'b1;
      end
   end

   // R4: a clear leaves the divider at zero
   p_div_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (div_q == '0));
   // R3: without a tick the divider does not move
   p_div_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(div_q));
endmodule

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
   parameter int RATE0_TICKS = 1024,
   parameter int RATE1_TICKS = 16,
   parameter int RATE2_TICKS = 64,
   parameter int RATE3_TICKS = 256,
   parameter int ACC_W       = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic [1:0] rate,
   output logic       step
);
   localparam int RATES [4] = '{RATE0_TICKS, RATE1_TICKS, RATE2_TICKS, RATE3_TICKS};

   logic [ACC_W-1:0] thr [4];
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;
   logic             hit;
   logic             adv;

   generate
      for (genvar i = 0; i < 4; i++) begin : g_thr
         assign thr[i] = ACC_W'(RATES[i]);
      end
   endgenerate

   assign adv  = tick && en;
   assign sum  = acc_q + 1'b1;
   assign hit  = (sum >= thr[rate]);
   assign step = adv && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (adv) acc_q <= hit ? (sum - thr[rate]) : sum;
   end

   // R7: accumulator holds whenever it is not advancing
   p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(acc_q));
   // R9: a step never fires without an enabled tick
   p_step_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (tick && en));
endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              wr_cnt,
   input  logic              wr_mod,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0] mod_q,
   output logic              irq_o
);
   logic              wrap;
   logic [DATA_W-1:0] reload_val;

   assign wrap       = step && (&cnt_q);
   assign reload_val = wr_mod ? wdata : mod_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mod_q <= '0;
         irq_o <= 1'b0;
      end else begin
         if (wr_mod) mod_q <= wdata;
         if (wr_cnt)    cnt_q <= wdata;
         else if (wrap) cnt_q <= reload_val;
         else if (step) cnt_q <= cnt_q + 1'b1;
         irq_o <= wrap && !wr_cnt;
      end
   end

   // R8: an unobstructed wrap raises the request on the next cycle
   p_wrap_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !wr_cnt) |=> irq_o);
   // R11: while the request is high the counter shows the modulo value
   p_irq_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cnt_q == mod_q));
   // R10: a counter write wins and suppresses the request
   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> ((cnt_q == $past(wdata)) && !irq_o));
endmodule

// File: rtl/prt_timer.sv
module prt_timer
   import prt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_TICKS   = 256,
   parameter int RATE0_TICKS = 1024,
   parameter int RATE1_TICKS = 16,
   parameter int RATE2_TICKS = 64,
   parameter int RATE3_TICKS = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [1:0]        bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int MAX_RATE = max_of4(RATE0_TICKS, RATE1_TICKS, RATE2_TICKS, RATE3_TICKS);
   localparam int ACC_W    = $clog2(MAX_RATE) + 1;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("prt_timer: DATA_W must be at least 4");
      end
      if (DIV_TICKS < 2) begin : g_bad_div
         $error("prt_timer: DIV_TICKS must be at least 2");
      end
      if (RATE0_TICKS < 1 || RATE1_TICKS < 1 || RATE2_TICKS < 1 || RATE3_TICKS < 1) begin : g_bad_rate
         $error("prt_timer: every rate must be at least one tick");
      end
   endgenerate

   prt_sel_e          sel;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] div_q;
   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] mod_q;
   logic              step;
   logic              wr_div, wr_cnt, wr_mod, wr_ctrl;

   assign sel     = prt_sel_e'(bus_sel);
   assign wr_div  = bus_wr && (sel == SEL_DIV);
   assign wr_cnt  = bus_wr && (sel == SEL_CNT);
   assign wr_mod  = bus_wr && (sel == SEL_MOD);
   assign wr_ctrl = bus_wr && (sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
   end

   prt_divider #(.DATA_W(DATA_W), .DIV_TICKS(DIV_TICKS)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_en),
      .clr   (wr_div),
      .div_q (div_q)
   );

   prt_prescaler #(
      .RATE0_TICKS (RATE0_TICKS),
      .RATE1_TICKS (RATE1_TICKS),
      .RATE2_TICKS (RATE2_TICKS),
      .RATE3_TICKS (RATE3_TICKS),
      .ACC_W       (ACC_W)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_en),
      .en    (ctrl_q[CTRL_EN]),
      .rate  (ctrl_q[1:0]),
      .step  (step)
   );

   prt_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .wr_cnt (wr_cnt),
      .wr_mod (wr_mod),
      .wdata  (bus_wdata),
      .cnt_q  (cnt_q),
      .mod_q  (mod_q),
      .irq_o  (irq_o)
   );

   always_comb begin
      unique case (sel)
         SEL_DIV:  bus_rdata = div_q;
         SEL_CNT:  bus_rdata = cnt_q;
         SEL_MOD:  bus_rdata = mod_q;
         default:  bus_rdata = {{(DATA_W-CTRL_W){1'b1}}, ctrl_q};
      endcase
   end

   // R6: upper control bits always read as ones
   p_ctrl_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_CTRL) |-> (&bus_rdata[DATA_W-1:CTRL_W]));
   // R7: a disabled counter holds unless written
   p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CTRL_EN] && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: tb/prt_timer_test.sv
module prt_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_o;

   int n_checks = 0;
   int n_errors = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   // scoreboard queues: kind 0 = read data, kind 1 = interrupt pulse count
   int    kind_q [$];
   int    exp_q  [$];
   string tag_q  [$];

   always #5 clk = ~clk;

   prt_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_wr    (bus_wr),
      .bus_sel   (bus_sel),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   // monitor: counts pulses, then pops and compares pending items
   always @(negedge clk) begin
      #2;
      if (rst_n && irq_o === 1'b1) irq_seen++;
      while (kind_q.size() > 0) begin
         int k, e, a;
         string t;
         k = kind_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = (k == 0) ? int'(bus_rdata) : irq_seen;
         n_checks++;
         if (a !== e) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", t, a, e);
         end
      end
   end

   task automatic expect_rd(input logic [1:0] sel, input int exp, input string tag);
      bus_sel = sel;
      bus_wr = 1'b0;
      kind_q.push_back(0); exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic expect_irq(input int exp, input string tag);
      kind_q.push_back(1); exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d, input bit with_tick);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1; tick_en = with_tick;
      @(negedge clk);
      bus_wr = 1'b0; tick_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      expect_rd(2'd0, 8'h00, "R1 divider");
      expect_rd(2'd1, 8'h00, "R1 counter");
      expect_rd(2'd2, 8'h00, "R1 modulo");
      expect_rd(2'd3, 8'hF8, "R1 control");
      expect_irq(0, "R1 irq");

      // R5 rate 1 (16 ticks), exact and one short
      wr(2'd3, 8'h05, 1'b0);
      ticks(16);
      expect_rd(2'd1, 8'h01, "R5 rate16 first");
      ticks(15);
      expect_rd(2'd1, 8'h01, "R5 rate16 one short");
      ticks(1);
      expect_rd(2'd1, 8'h02, "R5 rate16 second");
      wr(2'd3, 8'h06, 1'b0);
      ticks(64);
      expect_rd(2'd1, 8'h03, "R5 rate64");
      wr(2'd3, 8'h07, 1'b0);
      ticks(256);
      expect_rd(2'd1, 8'h04, "R5 rate256");
      wr(2'd3, 8'h04, 1'b0);
      ticks(1024);
      expect_rd(2'd1, 8'h05, "R5 rate1024");

      // R3 divider: 1376 ticks so far
      expect_rd(2'd0, 8'h05, "R3 divider count");

      // R4 divider clear with arbitrary data
      wr(2'd0, 8'h3C, 1'b0);
      expect_rd(2'd0, 8'h00, "R4 divider cleared");
      wr(2'd3, 8'h00, 1'b0);
      ticks(255);
      expect_rd(2'd0, 8'h00, "R4 sub-count cleared");
      ticks(1);
      expect_rd(2'd0, 8'h01, "R3 divider while disabled");

      // R6 / R2 control read
      wr(2'd3, 8'h02, 1'b0);
      expect_rd(2'd3, 8'hFA, "R6 control upper ones");
      wr(2'd3, 8'hF9, 1'b0);
      expect_rd(2'd3, 8'hF9, "R2 control write low bits");

      // R7 disable keeps accumulator and counter
      wr(2'd3, 8'h05, 1'b0);
      ticks(10);
      wr(2'd3, 8'h01, 1'b0);
      ticks(100);
      expect_rd(2'd1, 8'h05, "R7 held while disabled");
      wr(2'd3, 8'h05, 1'b0);
      ticks(5);
      expect_rd(2'd1, 8'h05, "R7 resumed accumulator short");
      ticks(1);
      expect_rd(2'd1, 8'h06, "R7 resumed accumulator step");

      // R8 overflow reload and single pulse
      wr(2'd2, 8'h42, 1'b0);
      wr(2'd1, 8'hFE, 1'b0);
      ticks(16);
      expect_rd(2'd1, 8'hFF, "R8 before wrap");
      expect_irq(0, "R8 no early irq");
      ticks(16);
      expect_irq(1, "R8 irq on wrap");
      expect_rd(2'd1, 8'h42, "R8 reloaded from modulo");
      ticks(1);
      expect_irq(1, "R8 one-cycle pulse");

      // R10 counter write wins over a wrap
      wr(2'd1, 8'hFF, 1'b0);
      ticks(14);
      wr(2'd1, 8'h10, 1'b1);
      expect_rd(2'd1, 8'h10, "R10 written value wins");
      expect_irq(1, "R10 no irq on overwritten wrap");

      // R11 same-cycle modulo write feeds the reload
      wr(2'd1, 8'hFF, 1'b0);
      ticks(15);
      wr(2'd2, 8'h77, 1'b1);
      expect_rd(2'd1, 8'h77, "R11 reload uses new modulo");
      expect_rd(2'd2, 8'h77, "R11 modulo stored");
      expect_irq(2, "R11 irq raised");

      // R9 carry after lowering the rate
      wr(2'd3, 8'h04, 1'b0);
      wr(2'd1, 8'h00, 1'b0);
      ticks(40);
      wr(2'd3, 8'h05, 1'b0);
      ticks(3);
      expect_rd(2'd1, 8'h02, "R9 back-to-back carry steps");
      ticks(4);
      expect_rd(2'd1, 8'h02, "R9 remainder kept");
      ticks(1);
      expect_rd(2'd1, 8'h03, "R9 remainder completes");
      expect_irq(2, "R9 no stray irq");

      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule